// File: doc/BRIEF.md
# Half-Word Swap and Sync Detector

This block sits behind a deserializer that hands over 20-bit parallel words but can only guarantee alignment to a 10-bit boundary. Each incoming word may therefore arrive with its two 10-bit halves in the wrong order. When the `swap_en` input is high, the block exchanges the upper and lower halves. The corrected word is registered and driven out one clock later.

At the same time the block hunts the corrected stream for the 10-bit sync pattern 10'h1A7 in the low half of each word. A small state machine counts detections. The states are HUNT (no detection yet), ARMED (one detection seen) and LOCKED (two or more seen). The transitions are:
- HUNT→ARMED on a detection.
- ARMED→LOCKED on a detection.
- LOCKED→LOCKED always.
- Every other case holds its state.
- Reset returns the machine to HUNT.

`data_valid` is high exactly while the machine is LOCKED, so downstream checking logic knows when to start comparing. Each channel uses its own instance, so each channel tracks sync on its own.

Top module: `hws_sync_aligner`

## Requirements
- R1: While `rst_n` is low, `aligned_word` is 0 and `data_valid` is 0.
- R2: With `swap_en` low, `aligned_word` equals the `rx_word` sampled at the previous rising clock edge.
- R3: With `swap_en` high, `aligned_word` equals the previous `rx_word` with its halves exchanged: bits [19:10] of the output are input bits [9:0], and bits [9:0] of the output are input bits [19:10].
- R4: A detection is counted only when bits [9:0] of the corrected word equal 10'h1A7. The pattern in bits [19:10] of the corrected word does not count.
- R5: `data_valid` rises in the same cycle that the word carrying the second detection appears on `aligned_word`. A single detection never raises it.
- R6: The two detections need not be adjacent. Words without the pattern between them do not clear the count.
- R7: Once `data_valid` is high, it stays high for any input until reset.
- R8: Reset clears the detection count. One detection before a reset plus one after it does not raise `data_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 20 | Parallel word from the deserializer |
| swap_en | input | 1 | High to exchange the two 10-bit halves |
| aligned_word | output | 20 | Registered, half-corrected word |
| data_valid | output | 1 | High once two sync detections have been seen |

## Verification
Every result of this block is due exactly one rising edge after the input that produces it. The corrected word appears one edge later. The `data_valid` change caused by a detecting word appears at that same edge, alongside the word.

The driver applies each input on a falling edge and queues the expected word and flag for that input. The monitor pops one queued item 1 ns after every rising edge. This pairs each input with the edge that registers it, with no extra offset. Reset values are checked while reset is held. Neutral words are driven before each reset so the queue is empty when reset starts.

// File: rtl/hws_pkg.sv
package hws_pkg;
    localparam int unsigned HWS_HALF_W   = 10;
    localparam int unsigned HWS_WORD_W   = 2 * HWS_HALF_W;
    localparam logic [HWS_HALF_W-1:0] HWS_SYNC_PAT = 10'h1A7;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } hws_state_e;
endpackage

// File: rtl/hws_swap_stage.sv
module hws_swap_stage #(
    parameter int unsigned HALF_W = 10,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              swap_en,
    output logic [WORD_W-1:0] fixed_comb,
    output logic [WORD_W-1:0] dout_q
);
    logic [WORD_W-1:0] exchanged;

    // Build the exchanged word half by half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign exchanged[h*HALF_W +: HALF_W] = din[(1-h)*HALF_W +: HALF_W];
    end

    assign fixed_comb = swap_en ? exchanged : din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= fixed_comb;
        end
    end
endmodule

// File: rtl/hws_pattern_match.sv
module hws_pattern_match #(
    parameter int unsigned HALF_W = 10,
    parameter logic [HALF_W-1:0] PATTERN = 10'h1A7,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit
);
    logic [HALF_W-1:0] low_half;

    assign low_half = word[HALF_W-1:0];
    assign hit      = (low_half == PATTERN);

    // The upper half takes no part in detection.
    logic unused_upper;
    assign unused_upper = ^word[WORD_W-1:HALF_W];
endmodule

// File: rtl/hws_sync_fsm.sv
module hws_sync_fsm
    import hws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    output hws_state_e state_o,
    output logic       lock_o
);
    hws_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (hit) state_d = ST_ARMED;
            ST_ARMED:  if (hit) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        state_o = state_q;
        lock_o  = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/hws_sync_aligner.sv
module hws_sync_aligner
    import hws_pkg::*;
#(
    parameter int unsigned HALF_W = HWS_HALF_W,
    parameter logic [HALF_W-1:0] PATTERN = HWS_SYNC_PAT,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              swap_en,
    output logic [WORD_W-1:0] aligned_word,
    output logic              data_valid
);
    logic [WORD_W-1:0] fixed_word;
    logic              det_hit;
    hws_state_e        fsm_state;

    hws_swap_stage #(.HALF_W(HALF_W)) u_swap (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (rx_word),
        .swap_en    (swap_en),
        .fixed_comb (fixed_word),
        .dout_q     (aligned_word)
    );

    hws_pattern_match #(.HALF_W(HALF_W), .PATTERN(PATTERN)) u_match (
        .word (fixed_word),
        .hit  (det_hit)
    );

    hws_sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (det_hit),
        .state_o (fsm_state),
        .lock_o  (data_valid)
    );
endmodule

// File: rtl/hws_sync_chk.sv
module hws_sync_chk
    import hws_pkg::*;
#(
    parameter int unsigned HALF_W = 10,
    parameter logic [HALF_W-1:0] PATTERN = 10'h1A7,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] rx_word,
    input logic              swap_en,
    input logic [WORD_W-1:0] aligned_word,
    input logic              data_valid,
    input hws_state_e        state,
    input logic              hit
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (aligned_word == '0 && !data_valid));

    a_r2_straight_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en |=> aligned_word == $past(rx_word));

    a_r3_half_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> (aligned_word[HALF_W-1:0] == $past(rx_word[WORD_W-1:HALF_W]) &&
                     aligned_word[WORD_W-1:HALF_W] == $past(rx_word[HALF_W-1:0])));

    a_r4_hunt_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && hit) |=> state == ST_ARMED);

    a_r5_rise_on_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> aligned_word[HALF_W-1:0] == PATTERN);

    a_r6_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ARMED |=> state != ST_HUNT);

    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid);
endmodule

bind hws_sync_aligner hws_sync_chk #(.HALF_W(HALF_W), .PATTERN(PATTERN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_word      (rx_word),
    .swap_en      (swap_en),
    .aligned_word (aligned_word),
    .data_valid   (data_valid),
    .state        (fsm_state),
    .hit          (det_hit)
);

// File: tb/tb_hws_sync_aligner.sv
`timescale 1ns/1ps
module tb_hws_sync_aligner;
    localparam logic [9:0] PAT = 10'h1A7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] rx_word = '0;
    logic        swap_en = 1'b0;
    logic [19:0] aligned_word;
    logic        data_valid;

    typedef struct {
        logic [19:0] w;
        logic        v;
        string       wtag;
        string       vtag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   det_cnt = 0;
    bit   done = 0;
    logic [19:0] lfsr = 20'h5C3E1;

    always #10 clk = ~clk;

    hws_sync_aligner dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_word      (rx_word),
        .swap_en      (swap_en),
        .aligned_word (aligned_word),
        .data_valid   (data_valid)
    );

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies an input and queues what must appear one edge later.
    task automatic drive(logic [19:0] w, logic s, string wtag, string vtag);
        exp_t e;
        logic [19:0] fixed;
        @(negedge clk);
        rx_word = w;
        swap_en = s;
        fixed = s ? {w[9:0], w[19:10]} : w;
        if (fixed[9:0] == PAT && det_cnt < 2) det_cnt++;
        e.w = fixed;
        e.v = (det_cnt >= 2);
        e.wtag = wtag;
        e.vtag = vtag;
        q.push_back(e);
    endtask

    function automatic logic [19:0] next_noise();
        lfsr = {lfsr[18:0], lfsr[19] ^ lfsr[16]};
        return (lfsr[9:0] == PAT) ? (lfsr ^ 20'h1) : lfsr;
    endfunction

    task automatic do_reset();
        drive(20'h00000, 1'b0, "R2", "R1");
        @(posedge clk);
        #2;
        @(negedge clk);
        rst_n = 1'b0;
        det_cnt = 0;
        @(posedge clk);
        #1;
        check("R1 word", aligned_word, 20'h0);
        check("R1 valid", {19'h0, data_valid}, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares one queued item per rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.wtag, aligned_word, e.w);
                check(e.vtag, {19'h0, data_valid}, {19'h0, e.v});
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        check("R1 word", aligned_word, 20'h0);
        check("R1 valid", {19'h0, data_valid}, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 straight words
        for (int i = 0; i < 8; i++) drive(next_noise(), 1'b0, "R2", "R5");
        // R3 exchanged words
        for (int i = 0; i < 8; i++) drive(next_noise(), 1'b1, "R3", "R5");
        drive(20'hFFFFF, 1'b1, "R3", "R5");
        drive(20'h003FF, 1'b1, "R3", "R5");
        // R4 pattern in upper half only: no count
        drive({PAT, 10'h000}, 1'b0, "R4", "R4");
        drive({PAT, 10'h155}, 1'b0, "R4", "R4");
        // R4 exchange brings pattern low: first detection
        drive({PAT, 10'h2AA}, 1'b1, "R4", "R5");
        // R6 gap of non-pattern words keeps the count
        for (int i = 0; i < 5; i++) drive(next_noise(), i[0], "R6", "R6");
        // R5 second detection: valid rises with this word
        drive({10'h0F0, PAT}, 1'b0, "R5", "R5");
        // R7 sticky
        for (int i = 0; i < 10; i++) drive(next_noise(), i[1], "R7", "R7");
        drive({PAT, PAT}, 1'b1, "R7", "R7");

        // R8 count cleared by reset
        do_reset();
        drive({10'h000, PAT}, 1'b0, "R8", "R8");
        do_reset();
        drive({PAT, 10'h000}, 1'b1, "R8", "R8");
        for (int i = 0; i < 3; i++) drive(next_noise(), 1'b0, "R8", "R8");
        // Then a second detection after this reset does lock (R5)
        drive({10'h3C3, PAT}, 1'b0, "R5", "R5");
        drive(20'h00000, 1'b0, "R7", "R7");

        @(posedge clk);
        #3;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule